// File: doc/BRIEF.md
# Serial Programming Port for a Dual-Loop Frequency Synthesiser

This block receives the programming words of a frequency synthesiser over three plain wires: serial data, serial clock and strobe. While strobe is low, each rising edge of the serial clock shifts one data bit into a 32-bit input register. The most significant bit comes first. When strobe rises, the block decides what kind of word has arrived. It uses the number of bits received and, for short words, a two-bit address in the lowest bits. It then moves the fields into the working registers that drive the divider, reference, auxiliary loop and current-scale logic.

One word kind sets the multimodulus mode, the cumulative cycle counts and the fractional value. This word is not applied at once. It waits in a staging register and is applied together with the next frequency word, so the whole new setting lands on one edge. Strobing a frequency word also asserts a speed-up output for the main loop, which stays high as long as strobe stays high. During that time, serial clock pulses have no effect.

The three serial wires are asynchronous to the core clock and pass through a synchroniser of `SYNC_STAGES` flops. They are level controls, not a stream, so the port has no valid/ready handshake and applies no back-pressure. The host alone sets the pace through the serial clock. Every field is a plain registered output.

Top module: `synth_load_port`

## Requirements
- R1: While strobe is low, each rising serial-clock edge shifts the data bit into the input register, most significant bit first, and adds one to a bit counter that saturates at 63.
- R2: A 24-bit word is classified by its bits [1:0]: 0 is the frequency word, 1 the staged mode word, 2 the auxiliary word, 3 the reference word. The frequency word sets `main_n1` from [23:12] and `main_n2` from [11:4]; its bits [3:2] are ignored.
- R3: The mode word sets `cum3` from [23:20], `cum4` from [19:16], `mod_sel` from [15:14] and `frac_num` from [13:2]. These outputs keep their old values until the next frequency word (24-bit or 32-bit) is strobed. At that point the most recently staged mode word is applied.
- R4: The auxiliary word sets `aux_n` from [23:10] and `aux_r` from [9:2]. The reference word sets `ref_r` from [23:13], `pd_mask` from [12:10] and `aux_gain` from [9:2]. Both take effect on their own strobe.
- R5: A 32-bit word is a long frequency word, whatever its bits [1:0]. It sets `main_cn` from [31:23+1], which is bits [31:24], and sets `main_n1` and `main_n2` from the same positions as the 24-bit frequency word. It also applies the staged mode word.
- R6: `speedup` rises on the strobe of a 24-bit or 32-bit frequency word. It stays high while strobe stays high and drops after strobe falls. Strobing the mode, auxiliary or reference word never raises it.
- R7: While strobe is high, serial-clock pulses change neither the input register nor any output.
- R8: A strobe whose bit count is neither 24 nor 32 changes no output. The falling edge of strobe clears the bit counter, so the next word always starts from zero.
- R9: After reset, every field output and `speedup` are 0.
- R10: A strobe rise that reaches the input pin just after a core-clock edge shows at the outputs SYNC_STAGES+1 core clocks later, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial shift clock |
| ser_strobe | input | 1 | Word strobe |
| main_n1 | output | 12 | Main divider first-modulus count |
| main_n2 | output | 8 | Main divider second-modulus count |
| main_cn | output | 8 | Proportional current scale |
| mod_sel | output | 2 | Prescaler modulus mode (0: two, 1: three, 2: four) |
| cum3 | output | 4 | Cumulative count up to the third modulus |
| cum4 | output | 4 | Cumulative count up to the fourth modulus |
| frac_num | output | 12 | Fractional interpolation value |
| aux_n | output | 14 | Auxiliary divider value |
| aux_r | output | 8 | Auxiliary reference value |
| ref_r | output | 11 | Reference divider value |
| pd_mask | output | 3 | Power-down flags |
| aux_gain | output | 8 | Auxiliary charge-pump scale |
| speedup | output | 1 | Main loop speed-up mode |

## Verification
On every cycle, the assertions check four things:
- `speedup` is only high while the synchronised strobe is high.
- Nothing shifts and no output moves while strobe is held high.
- The staged mode fields never move except on a frequency-word strobe.
- The counter is cleared after each strobe fall.

Other behaviour can only be shown by scenarios: that each word lands in the correct field bits, that staging defers the mode word until the next frequency word, that words of a wrong length are discarded, and the exact latency from a strobe edge.

// File: rtl/synth_load_pkg.sv
package synth_load_pkg;
  localparam int SR_W      = 32;
  localparam int SHORT_LEN = 24;
  localparam int LONG_LEN  = 32;
  localparam int CNT_W     = 6;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [2:0] {
    WK_NONE = 3'd0,
    WK_FREQ = 3'd1,
    WK_MODE = 3'd2,
    WK_AUX  = 3'd3,
    WK_REF  = 3'd4,
    WK_LONG = 3'd5
  } word_kind_e;

  typedef struct packed {
    logic [3:0]  cum3;
    logic [3:0]  cum4;
    logic [1:0]  mod_sel;
    logic [11:0] frac;
  } mode_fields_t;
endpackage

// File: rtl/synth_load_sync.sv
module synth_load_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/synth_load_shift.sv
module synth_load_shift
  import synth_load_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dat_s,
  input  logic             sck_s,
  input  logic             str_s,
  output logic [SR_W-1:0]  sr,
  output logic [CNT_W-1:0] cnt,
  output logic             str_q,
  output logic             str_rise
);
  logic sck_q;
  logic sck_rise, str_fall;

  assign sck_rise = sck_s & ~sck_q;
  assign str_rise = str_s & ~str_q;
  assign str_fall = ~str_s & str_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      str_q <= 1'b0;
      sr    <= '0;
      cnt   <= '0;
    end else begin
      sck_q <= sck_s;
      str_q <= str_s;
      if (str_fall) begin
        cnt <= '0;
      end else if (sck_rise && !str_s) begin
        sr <= {sr[SR_W-2:0], dat_s};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end

  // R7: with strobe high the input register cannot move
  a_r7_no_shift_high: assert property (@(posedge clk) disable iff (!rst_n)
    str_s |=> $stable(sr));

  // R8: a falling strobe leaves the counter at zero
  a_r8_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!str_s && str_q) |=> (cnt == '0));
endmodule

// File: rtl/synth_load_decode.sv
module synth_load_decode
  import synth_load_pkg::*;
(
  input  logic [CNT_W-1:0] cnt,
  input  logic [1:0]       addr,
  output word_kind_e       kind
);
  always_comb begin
    kind = WK_NONE;
    if (cnt == CNT_W'(LONG_LEN)) begin
      kind = WK_LONG;
    end else if (cnt == CNT_W'(SHORT_LEN)) begin
      case (addr)
        2'd0:    kind = WK_FREQ;
        2'd1:    kind = WK_MODE;
        2'd2:    kind = WK_AUX;
        default: kind = WK_REF;
      endcase
    end
  end
endmodule

// File: rtl/synth_load_regs.sv
module synth_load_regs
  import synth_load_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SR_W-1:0] sr,
  input  word_kind_e      kind,
  input  logic            str_s,
  input  logic            str_q,
  input  logic            str_rise,
  output logic [11:0]     main_n1,
  output logic [7:0]      main_n2,
  output logic [7:0]      main_cn,
  output mode_fields_t    mode_o,
  output logic [13:0]     aux_n,
  output logic [7:0]      aux_r,
  output logic [10:0]     ref_r,
  output logic [2:0]      pd_mask,
  output logic [7:0]      aux_gain,
  output logic            speedup
);
  mode_fields_t staged;
  logic         is_freq;
  logic         unused_bits;

  assign is_freq     = (kind == WK_FREQ) || (kind == WK_LONG);
  assign unused_bits = ^sr[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_n1  <= '0;
      main_n2  <= '0;
      main_cn  <= '0;
      mode_o   <= '0;
      staged   <= '0;
      aux_n    <= '0;
      aux_r    <= '0;
      ref_r    <= '0;
      pd_mask  <= '0;
      aux_gain <= '0;
      speedup  <= 1'b0;
    end else if (str_rise) begin
      if (is_freq) begin
        main_n1 <= sr[23:12];
        main_n2 <= sr[11:4];
        mode_o  <= staged;
        speedup <= 1'b1;
      end
      case (kind)
        WK_LONG: main_cn <= sr[31:24];
        WK_MODE: staged  <= '{cum3: sr[23:20], cum4: sr[19:16],
                              mod_sel: sr[15:14], frac: sr[13:2]};
        WK_AUX: begin
          aux_n <= sr[23:10];
          aux_r <= sr[9:2];
        end
        WK_REF: begin
          ref_r    <= sr[23:13];
          pd_mask  <= sr[12:10];
          aux_gain <= sr[9:2];
        end
        default: ;
      endcase
    end else if (!str_s) begin
      speedup <= 1'b0;
    end
  end

  // R6: speed-up only while the strobe is held
  a_r6_speedup_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    speedup |-> str_q);

  // R6: speed-up only starts from a strobe edge
  a_r6_speedup_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(speedup) |-> $past(str_rise));

  // R3: applied mode fields move only with a frequency word
  a_r3_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(str_rise && is_freq) |=> $stable(mode_o));

  // R7: outputs are frozen while strobe stays high
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (str_s && str_q) |=> $stable({main_n1, main_n2, main_cn, mode_o, aux_n,
                                  aux_r, ref_r, pd_mask, aux_gain}));
endmodule

// File: rtl/synth_load_port.sv
module synth_load_port
  import synth_load_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_data,
  input  logic        ser_clk,
  input  logic        ser_strobe,
  output logic [11:0] main_n1,
  output logic [7:0]  main_n2,
  output logic [7:0]  main_cn,
  output logic [1:0]  mod_sel,
  output logic [3:0]  cum3,
  output logic [3:0]  cum4,
  output logic [11:0] frac_num,
  output logic [13:0] aux_n,
  output logic [7:0]  aux_r,
  output logic [10:0] ref_r,
  output logic [2:0]  pd_mask,
  output logic [7:0]  aux_gain,
  output logic        speedup
);
  localparam int NWIRES = 3;

  logic [NWIRES-1:0] wires_s;
  logic [SR_W-1:0]   sr;
  logic [CNT_W-1:0]  cnt;
  logic              str_q, str_rise;
  word_kind_e        kind;
  mode_fields_t      mode_w;

  synth_load_sync #(.WIDTH(NWIRES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_strobe, ser_clk, ser_data}), .q(wires_s)
  );

  synth_load_shift u_shift (
    .clk(clk), .rst_n(rst_n),
    .dat_s(wires_s[0]), .sck_s(wires_s[1]), .str_s(wires_s[2]),
    .sr(sr), .cnt(cnt), .str_q(str_q), .str_rise(str_rise)
  );

  synth_load_decode u_dec (
    .cnt(cnt), .addr(sr[1:0]), .kind(kind)
  );

  synth_load_regs u_regs (
    .clk(clk), .rst_n(rst_n), .sr(sr), .kind(kind),
    .str_s(wires_s[2]), .str_q(str_q), .str_rise(str_rise),
    .main_n1(main_n1), .main_n2(main_n2), .main_cn(main_cn),
    .mode_o(mode_w), .aux_n(aux_n), .aux_r(aux_r), .ref_r(ref_r),
    .pd_mask(pd_mask), .aux_gain(aux_gain), .speedup(speedup)
  );

  assign mod_sel  = mode_w.mod_sel;
  assign cum3     = mode_w.cum3;
  assign cum4     = mode_w.cum4;
  assign frac_num = mode_w.frac;
endmodule

// File: tb/tb_synth_load_port.sv
`timescale 1ns/1ps
module tb_synth_load_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_strobe = 1'b0;
  logic [11:0] main_n1; logic [7:0] main_n2, main_cn;
  logic [1:0] mod_sel; logic [3:0] cum3, cum4; logic [11:0] frac_num;
  logic [13:0] aux_n; logic [7:0] aux_r; logic [10:0] ref_r;
  logic [2:0] pd_mask; logic [7:0] aux_gain; logic speedup;

  int checks = 0, errors = 0;

  // expected state
  logic [11:0] e_n1 = 0; logic [7:0] e_n2 = 0, e_cn = 0;
  logic [1:0] e_ms = 0; logic [3:0] e_c3 = 0, e_c4 = 0; logic [11:0] e_fr = 0;
  logic [1:0] s_ms = 0; logic [3:0] s_c3 = 0, s_c4 = 0; logic [11:0] s_fr = 0;
  logic [13:0] e_an = 0; logic [7:0] e_ar = 0; logic [10:0] e_rr = 0;
  logic [2:0] e_pm = 0; logic [7:0] e_ag = 0;

  always #2.5 clk = ~clk;

  synth_load_port dut (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_strobe(ser_strobe), .main_n1(main_n1), .main_n2(main_n2),
    .main_cn(main_cn), .mod_sel(mod_sel), .cum3(cum3), .cum4(cum4),
    .frac_num(frac_num), .aux_n(aux_n), .aux_r(aux_r), .ref_r(ref_r),
    .pd_mask(pd_mask), .aux_gain(aux_gain), .speedup(speedup)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " n1"}, 32'(main_n1), 32'(e_n1));
    chk({tag, " n2"}, 32'(main_n2), 32'(e_n2));
    chk({tag, " cn"}, 32'(main_cn), 32'(e_cn));
    chk({tag, " mode"}, {14'd0, cum3, cum4, mod_sel, frac_num}, {14'd0, e_c3, e_c4, e_ms, e_fr});
    chk({tag, " aux"}, {10'd0, aux_n, aux_r}, {10'd0, e_an, e_ar});
    chk({tag, " ref"}, {10'd0, ref_r, pd_mask, aux_gain}, {10'd0, e_rr, e_pm, e_ag});
  endtask

  task automatic send(input logic [31:0] w, input int n);
    for (int b = n - 1; b >= 0; b--) begin
      ser_data = w[b];
      waitn(3);
      ser_clk = 1'b1;
      waitn(3);
      ser_clk = 1'b0;
      waitn(1);
    end
  endtask

  // strobe, check speed-up level while high, release
  task automatic strobe(input string tag, input logic exp_sp);
    ser_strobe = 1'b1;
    waitn(6);
    chk({tag, " R6 speedup high phase"}, 32'(speedup), 32'(exp_sp));
    ser_strobe = 1'b0;
    waitn(6);
    chk({tag, " R6 speedup after fall"}, 32'(speedup), 32'd0);
  endtask

  task automatic apply_freq();
    e_ms = s_ms; e_c3 = s_c3; e_c4 = s_c4; e_fr = s_fr;
  endtask

  initial begin
    waitn(4);
    rst_n = 1'b1;
    waitn(2);
    chk_all("R9 reset");
    chk("R9 reset speedup", 32'(speedup), 32'd0);

    // R1 R2: frequency word sweep, reserved bits vary
    for (int i = 0; i < 8; i++) begin
      e_n1 = 12'((i * 517 + 3) & 12'hfff);
      e_n2 = 8'((i * 37 + 1) & 8'hff);
      send({8'd0, e_n1, e_n2, 2'(i), 2'd0}, 24);
      apply_freq();
      strobe("R2 freq", 1'b1);
      chk_all("R1 R2 freq sweep");
    end

    // R3: mode word is staged
    for (int i = 0; i < 4; i++) begin
      s_c3 = 4'(i * 5 + 2); s_c4 = 4'(i * 3 + 7); s_ms = 2'(i % 3); s_fr = 12'(i * 911 + 5);
      send({8'd0, s_c3, s_c4, s_ms, s_fr, 2'd1}, 24);
      strobe("R3 mode", 1'b0);
      chk_all("R3 staged not applied");
      e_n1 = 12'(100 + i); e_n2 = 8'(i);
      send({8'd0, e_n1, e_n2, 4'd0}, 24);
      apply_freq();
      strobe("R3 freq commit", 1'b1);
      chk_all("R3 committed with freq");
    end

    // R4: auxiliary and reference words
    for (int i = 0; i < 4; i++) begin
      e_an = 14'(i * 3001 + 9); e_ar = 8'(i * 71 + 4);
      send({8'd0, e_an, e_ar, 2'd2}, 24);
      strobe("R4 aux", 1'b0);
      chk_all("R4 aux word");
      e_rr = 11'(i * 613 + 1); e_pm = 3'(i + 3); e_ag = 8'(255 - i * 19);
      send({8'd0, e_rr, e_pm, e_ag, 2'd3}, 24);
      strobe("R4 ref", 1'b0);
      chk_all("R4 ref word");
    end

    // R5: long word, staged mode applied, address bits ignored
    s_c3 = 4'hc; s_c4 = 4'h3; s_ms = 2'd2; s_fr = 12'ha5c;
    send({8'd0, s_c3, s_c4, s_ms, s_fr, 2'd1}, 24);
    strobe("R5 mode", 1'b0);
    for (int i = 0; i < 4; i++) begin
      e_cn = 8'(i * 61 + 17); e_n1 = 12'(4000 - i * 7); e_n2 = 8'(i * 9 + 200);
      send({e_cn, e_n1, e_n2, 2'd3, 2'(i)}, 32);
      apply_freq();
      strobe("R5 long", 1'b1);
      chk_all("R5 long word");
    end

    // R7: serial clock pulses during a held strobe
    send({8'd0, 12'h123, 8'h45, 4'd0}, 24);
    e_n1 = 12'h123; e_n2 = 8'h45; apply_freq();
    ser_strobe = 1'b1;
    waitn(6);
    send(32'hffff_fffe, 24);
    chk("R7 speedup kept while pulsing", 32'(speedup), 32'd1);
    chk_all("R7 pulses ignored");
    ser_strobe = 1'b0;
    waitn(6);
    chk_all("R7 after release");

    // R8: wrong lengths discarded, counter restarts
    send({8'd0, 11'h7ff, 3'd7, 8'hff, 2'd3}, 23);
    strobe("R8 short", 1'b0);
    chk_all("R8 23-bit discarded");
    send({7'd0, 11'h7ff, 3'd7, 8'hff, 3'd3}, 25);
    strobe("R8 long25", 1'b0);
    chk_all("R8 25-bit discarded");
    e_rr = 11'h2aa; e_pm = 3'd5; e_ag = 8'h3c;
    send({8'd0, e_rr, e_pm, e_ag, 2'd3}, 24);
    strobe("R8 fresh", 1'b0);
    chk_all("R8 count restarted");

    // R10: latency of SYNC_STAGES+1 clocks
    e_an = 14'h1abc; e_ar = 8'h99;
    send({8'd0, e_an, e_ar, 2'd2}, 24);
    ser_strobe = 1'b1;
    waitn(2);
    chk("R10 not yet updated", 32'(aux_n), 32'(14'h0001 * 0 + (3 * 3001 + 9)));
    waitn(1);
    chk("R10 updated on third clock", 32'(aux_n), 32'(e_an));
    ser_strobe = 1'b0;
    waitn(6);
    chk_all("R10 final");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule